// File: doc/BRIEF.md
# Dual-Clock Presettable Up/Down Counter

A four-bit binary counter (modulus 2^WIDTH, default 16) whose direction is set by which of two clock pins gets a low pulse. A low pulse on `clk_up` adds one to the count and a low pulse on `clk_dn` subtracts one. The idle clock must stay high, and the change lands on the rising edge that ends the pulse. Every bit of the count changes on that edge together. The count can be forced to a value by an active-low load input and cleared by an active-high clear. Neither needs a clock edge, and clear wins when both are asserted.

The two active-low terminal outputs carry the count into a neighbour. `carry_n` goes low while the count sits at its maximum and the up clock is low. It rises again on the same edge that wraps the count to zero. `borrow_n` does the same job at zero for the down clock. Wiring them to the up and down clocks of a second unit gives a wider counter. Wiring `borrow_n` back to `load_n` gives a down counter that restarts from a chosen value.

Top module: `udc_dualclk`

## Requirements
- R1: While `clr` is high the count is 0 at once, with no clock edge. With both clocks high after clear, `carry_n` and `borrow_n` are both 1.
- R2: A low pulse on `clk_up` while `clk_dn` is high adds one to the count on its rising edge. The count does not change during the low phase.
- R3: A low pulse on `clk_dn` while `clk_up` is high subtracts one from the count on its rising edge.
- R4: Counting up from the maximum (15) gives 0, and counting down from 0 gives 15.
- R5: A low level on `load_n` copies `preset_val` into the count at once. Count pulses that end while `load_n` is low leave the preset value in place.
- R6: When `clr` and `load_n` are asserted together, the count is 0.
- R7: `carry_n` is 0 exactly while the count is at its maximum and `clk_up` is low. It is 1 again after the rising edge that wraps the count.
- R8: `borrow_n` is 0 exactly while the count is 0 and `clk_dn` is low. It is 1 again after the rising edge that wraps the count to the maximum.
- R9: With a second unit clocked from the first unit's `carry_n` and `borrow_n`, the pair counts as one 8-bit value in both directions.
- R10: With `borrow_n` fed back to `load_n` and a preset of 5, the values seen after each down pulse repeat 4, 3, 2, 1, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_up | input | 1 | Up clock; a low pulse increments on its rising edge |
| clk_dn | input | 1 | Down clock; a low pulse decrements on its rising edge |
| clr | input | 1 | Asynchronous clear to zero, active high, overrides load |
| load_n | input | 1 | Asynchronous parallel load, active low |
| preset_val | input | WIDTH | Value copied in while loading |
| count | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low terminal count in the up direction |
| borrow_n | output | 1 | Active-low terminal count in the down direction |

## Verification
The up clock is walked through the full range from zero. This shows that each edge adds exactly one, that nothing moves during the low phase, and that the carry is low only at the top value. A down run from zero tells the borrow and the wrap to 15 apart from plain decrements. Loading and clearing are applied between pulses and during pulses, which separates the level-driven paths from edge counting and shows the priority of clear. The two-stage chain and the borrow-to-load loop test the terminal outputs as real clocks, where a wrong edge or a wrong level changes the upper digit or the cycle length.

// File: rtl/udc_pkg.sv
package udc_pkg;
  typedef enum logic {DIR_DN = 1'b0, DIR_UP = 1'b1} udc_dir_e;
endpackage

// File: rtl/udc_edge_sel.sv
// Merges the two count clocks into one edge. The direction is latched when
// a pulse starts, so it is stable at the rising edge that ends the pulse.
module udc_edge_sel
  import udc_pkg::*;
(
  input  logic     clk_up,
  input  logic     clk_dn,
  input  logic     clr,
  output logic     cnt_clk,
  output udc_dir_e dir
);
  assign cnt_clk = clk_up & clk_dn;

  always_ff @(negedge cnt_clk or posedge clr) begin
    if (clr) dir <= DIR_UP;
    else     dir <= (!clk_up) ? DIR_UP : DIR_DN;
  end
endmodule

// File: rtl/udc_core.sv
// Count register: async clear beats async load, and both beat counting.
module udc_core
  import udc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             cnt_clk,
  input  udc_dir_e         dir,
  input  logic             clr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] preset_val,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

  always_ff @(posedge cnt_clk or posedge clr or negedge load_n) begin
    if (clr)                q <= '0;
    else if (!load_n)       q <= preset_val;
    else if (dir == DIR_UP) q <= q + STEP;
    else                    q <= q - STEP;
  end
endmodule

// File: rtl/udc_term.sv
// Terminal-count decode, gated by the low phase of the matching clock.
module udc_term #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             clk_up,
  input  logic             clk_dn,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam logic [WIDTH-1:0] Q_MAX = '1;
  localparam logic [WIDTH-1:0] Q_MIN = '0;

  always_comb begin
    carry_n  = !((q == Q_MAX) && !clk_up);
    borrow_n = !((q == Q_MIN) && !clk_dn);
  end
endmodule

// File: rtl/udc_dualclk.sv
module udc_dualclk
  import udc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_up,
  input  logic             clk_dn,
  input  logic             clr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] preset_val,
  output logic [WIDTH-1:0] count,
  output logic             carry_n,
  output logic             borrow_n
);
  logic     cnt_clk;
  udc_dir_e dir;

  udc_edge_sel u_edge (
    .clk_up (clk_up),
    .clk_dn (clk_dn),
    .clr    (clr),
    .cnt_clk(cnt_clk),
    .dir    (dir)
  );

  udc_core #(.WIDTH(WIDTH)) u_core (
    .cnt_clk   (cnt_clk),
    .dir       (dir),
    .clr       (clr),
    .load_n    (load_n),
    .preset_val(preset_val),
    .q         (count)
  );

  udc_term #(.WIDTH(WIDTH)) u_term (
    .q       (count),
    .clk_up  (clk_up),
    .clk_dn  (clk_dn),
    .carry_n (carry_n),
    .borrow_n(borrow_n)
  );
endmodule

// File: rtl/udc_dualclk_chk.sv
module udc_dualclk_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk_up,
  input logic             clk_dn,
  input logic             clr,
  input logic             load_n,
  input logic [WIDTH-1:0] preset_val,
  input logic [WIDTH-1:0] count,
  input logic             carry_n,
  input logic             borrow_n
);
  localparam logic [WIDTH-1:0] TOP = '1;

  // R1: the count is zero when clear is released
  p_clear_zero_r1: assert property (@(negedge clr) count == '0);

  // R5: the count holds the preset when the load is released
  p_load_value_r5: assert property (@(posedge load_n) disable iff (clr)
    count == preset_val);

  // R6: clear already active keeps the count at zero when a load starts
  p_clr_over_load_r6: assert property (@(negedge load_n)
    clr |-> count == '0);

  // R7: carry is low at the top value just before the wrapping edge
  p_carry_wrap_r7: assert property (@(posedge clk_up) disable iff (clr || !load_n)
    (count == TOP) |-> !carry_n);

  // R8: borrow is low at zero just before the wrapping edge
  p_borrow_wrap_r8: assert property (@(posedge clk_dn) disable iff (clr || !load_n)
    (count == '0) |-> !borrow_n);
endmodule

bind udc_dualclk udc_dualclk_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_up    (clk_up),
  .clk_dn    (clk_dn),
  .clr       (clr),
  .load_n    (load_n),
  .preset_val(preset_val),
  .count     (count),
  .carry_n   (carry_n),
  .borrow_n  (borrow_n)
);

// File: tb/udc_dualclk_test.sv
module udc_dualclk_test;
  localparam int W = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // unit under test
  logic         clk_up = 1'b1;
  logic         clk_dn = 1'b1;
  logic         clr = 1'b1;
  logic         load_n = 1'b1;
  logic [W-1:0] preset_val = '0;
  logic [W-1:0] count;
  logic         carry_n, borrow_n;

  udc_dualclk #(.WIDTH(W)) uut (
    .clk_up(clk_up), .clk_dn(clk_dn), .clr(clr), .load_n(load_n),
    .preset_val(preset_val), .count(count), .carry_n(carry_n), .borrow_n(borrow_n)
  );

  // two-stage chain
  logic         aux_clr = 1'b1;
  logic         lo_up = 1'b1;
  logic         lo_dn = 1'b1;
  logic [W-1:0] lo_cnt, hi_cnt;
  logic         lo_carry_n, lo_borrow_n, hi_carry_n, hi_borrow_n;

  udc_dualclk #(.WIDTH(W)) u_lo (
    .clk_up(lo_up), .clk_dn(lo_dn), .clr(aux_clr), .load_n(1'b1),
    .preset_val('0), .count(lo_cnt), .carry_n(lo_carry_n), .borrow_n(lo_borrow_n)
  );
  udc_dualclk #(.WIDTH(W)) u_hi (
    .clk_up(lo_carry_n), .clk_dn(lo_borrow_n), .clr(aux_clr), .load_n(1'b1),
    .preset_val('0), .count(hi_cnt), .carry_n(hi_carry_n), .borrow_n(hi_borrow_n)
  );

  // recycling down counter: borrow fed back to load
  logic         m_dn = 1'b1;
  logic [W-1:0] m_cnt;
  logic         m_carry_n, m_borrow_n;
  wire          m_load_n;
  assign #1 m_load_n = m_borrow_n;

  udc_dualclk #(.WIDTH(W)) u_m5 (
    .clk_up(1'b1), .clk_dn(m_dn), .clr(aux_clr), .load_n(m_load_n),
    .preset_val(W'(5)), .count(m_cnt), .carry_n(m_carry_n), .borrow_n(m_borrow_n)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_up(input logic v);
    @(posedge clk); clk_up <= v; @(negedge clk);
  endtask

  task automatic set_dn(input logic v);
    @(posedge clk); clk_dn <= v; @(negedge clk);
  endtask

  task automatic pulse_up();
    set_up(1'b0); set_up(1'b1);
  endtask

  task automatic pulse_dn();
    set_dn(1'b0); set_dn(1'b1);
  endtask

  task automatic do_clear();
    @(posedge clk); clr <= 1'b1; @(negedge clk);
    @(posedge clk); clr <= 1'b0; @(negedge clk);
  endtask

  task automatic t_reset();
    // R1: clear zeroes the count with no count edge
    @(posedge clk); load_n <= 1'b0; preset_val <= W'(7); @(negedge clk);
    @(posedge clk); load_n <= 1'b1; @(negedge clk);
    @(posedge clk); clr <= 1'b1; @(negedge clk);
    check("R1 count during clear", int'(count), 0);
    @(posedge clk); clr <= 1'b0; @(negedge clk);
    check("R1 carry_n after clear", int'(carry_n), 1);
    check("R1 borrow_n after clear", int'(borrow_n), 1);
  endtask

  task automatic t_up_run();
    do_clear();
    for (int i = 1; i <= 15; i++) begin
      set_up(1'b0);
      check("R2 count held during low phase", int'(count), i - 1);
      check("R7 carry_n below top", int'(carry_n), 1);
      set_up(1'b1);
      check("R2 increment", int'(count), i);
    end
    check("R7 carry_n at top with clock high", int'(carry_n), 1);
    set_up(1'b0);
    check("R7 carry_n at top with clock low", int'(carry_n), 0);
    set_up(1'b1);
    check("R4 wrap up to zero", int'(count), 0);
    check("R7 carry_n after wrap", int'(carry_n), 1);
  endtask

  task automatic t_down_run();
    do_clear();
    set_dn(1'b0);
    check("R8 borrow_n at zero with clock low", int'(borrow_n), 0);
    check("R7 carry_n stays high on down pulse", int'(carry_n), 1);
    set_dn(1'b1);
    check("R4 wrap down to top", int'(count), 15);
    check("R8 borrow_n after wrap", int'(borrow_n), 1);
    for (int i = 1; i <= 3; i++) pulse_dn();
    check("R3 decrement", int'(count), 12);
    pulse_up();
    pulse_dn();
    pulse_dn();
    check("R3 mixed directions", int'(count), 11);
  endtask

  task automatic t_load();
    do_clear();
    pulse_up(); pulse_up();
    @(posedge clk); preset_val <= W'(9); load_n <= 1'b0; @(negedge clk);
    check("R5 async load", int'(count), 9);
    pulse_up();
    check("R5 up pulse ignored during load", int'(count), 9);
    pulse_dn();
    check("R5 down pulse ignored during load", int'(count), 9);
    @(posedge clk); load_n <= 1'b1; @(negedge clk);
    check("R5 value held after load", int'(count), 9);
    pulse_up();
    check("R5 counting resumes from preset", int'(count), 10);
    // load started within a low clock phase, released before the rising edge
    set_dn(1'b0);
    @(posedge clk); preset_val <= W'(3); load_n <= 1'b0; @(negedge clk);
    @(posedge clk); load_n <= 1'b1; @(negedge clk);
    set_dn(1'b1);
    check("R5 load during low phase then edge", int'(count), 2);
  endtask

  task automatic t_priority();
    do_clear();
    pulse_up(); pulse_up(); pulse_up();
    @(posedge clk); clr <= 1'b1; @(negedge clk);
    @(posedge clk); preset_val <= W'(10); load_n <= 1'b0; @(negedge clk);
    check("R6 clear overrides load", int'(count), 0);
    pulse_up();
    check("R6 clear overrides load and count", int'(count), 0);
    @(posedge clk); load_n <= 1'b1; @(negedge clk);
    @(posedge clk); clr <= 1'b0; @(negedge clk);
    check("R6 zero after both released", int'(count), 0);
  endtask

  task automatic chain_up();
    @(posedge clk); lo_up <= 1'b0; @(negedge clk);
    @(posedge clk); lo_up <= 1'b1; @(negedge clk);
  endtask

  task automatic chain_dn();
    @(posedge clk); lo_dn <= 1'b0; @(negedge clk);
    @(posedge clk); lo_dn <= 1'b1; @(negedge clk);
  endtask

  task automatic t_cascade();
    @(posedge clk); aux_clr <= 1'b1; @(negedge clk);
    @(posedge clk); aux_clr <= 1'b0; @(negedge clk);
    check("R9 chain starts at zero", int'({hi_cnt, lo_cnt}), 0);
    for (int i = 0; i < 16; i++) chain_up();
    check("R9 carry into upper stage", int'({hi_cnt, lo_cnt}), 16);
    for (int i = 0; i < 20; i++) chain_up();
    check("R9 chain up to 36", int'({hi_cnt, lo_cnt}), 36);
    for (int i = 0; i < 5; i++) chain_dn();
    check("R9 borrow from upper stage", int'({hi_cnt, lo_cnt}), 31);
    for (int i = 0; i < 32; i++) chain_dn();
    check("R9 chain wraps below zero", int'({hi_cnt, lo_cnt}), 255);
  endtask

  task automatic t_mod5();
    @(posedge clk); aux_clr <= 1'b1; @(negedge clk);
    @(posedge clk); aux_clr <= 1'b0; @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); m_dn <= 1'b0; @(negedge clk);
      @(posedge clk); m_dn <= 1'b1; @(negedge clk);
      check("R10 recycling down sequence", int'(m_cnt), 4 - (i % 5));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    step(); step();
    t_reset();
    t_up_run();
    t_down_run();
    t_load();
    t_priority();
    t_cascade();
    t_mod5();
    step();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule